// File: doc/BRIEF.md
# Configurable Pad I/O Cell

This block sits between one bidirectional package pad (split here into a sensed value, a driven value and a drive enable) and the programmable fabric. A 6-bit configuration word, held static while the cell runs, chooses how the pad is sampled, how fabric data reaches the pad and when the pad driver is switched on. The cell is a vector of `WIDTH` identical bit slices that share the clocks, the configuration, the clock enable and the latch control.

On the receive side the primary fabric output can take the pad through a register, directly, through a register followed by a latch, or through a latch only. A secondary output always samples the pad on the opposite edge of the input clock, which gives double-data-rate capture. On the transmit side the pad can carry a double-data-rate stream, the fabric data directly, a registered copy of it or a registered inverse of it. The driver enable can be off, always on, taken from the fabric, or registered from the fabric. A single option inverts the sense of every clock edge in the cell.

Top module: `pad_cell`

## Requirements
- R1: While `rst_n` is low every register and latch in the cell holds 0; with `cfg_type` = 6'b000000 the outputs `din0`, `din1`, `pad_o` and `pad_oe` all read 0.
- R2: Receive field `cfg_type[1:0]` = 2'b00: `din0` shows the pad value captured at the rising input-clock edge and changes only at that edge.
- R3: Receive field 2'b01 (for example `cfg_type` = 6'b000001): `din0` follows `pad_i` with no clock.
- R4: Receive field 2'b11: `din0` follows `pad_i` while `lat_hold` is 0 and keeps its value while `lat_hold` is 1; field 2'b10 places the same latch behind the rising-edge capture register.
- R5: `din1` shows the pad value captured at the falling input-clock edge, whatever the receive field.
- R6: While `clk_en` is 0 no register of the cell (receive, transmit or enable) changes.
- R7: Transmit field `cfg_type[3:2]` = 2'b10: `pad_o` equals `dout0` with no clock; `cfg_type` = 6'b011001 gives a plain output whose driver is always on.
- R8: Transmit field 2'b01: `pad_o` is `dout0` captured at the rising output-clock edge; field 2'b11: the bitwise inverse of `dout0` captured at that edge.
- R9: Transmit field 2'b00: `dout0` is captured at the rising and `dout1` at the falling output-clock edge; `pad_o` shows the first while the output clock is high and the second while it is low.
- R10: Enable field `cfg_type[5:4]`: 2'b00 keeps `pad_oe` at 0, 2'b01 holds it at all ones, 2'b10 passes `oe_i`, 2'b11 gives `oe_i` captured at the rising output-clock edge.
- R11: With `cfg_neg_clk` = 1 every register captures on the opposite edge and the double-rate transmit selection is reversed, so `pad_o` shows the `dout1` register while the output clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Receive-side clock |
| clk_out | input | 1 | Transmit and enable clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_type | input | 6 | Static mode word: [1:0] receive, [3:2] transmit, [5:4] enable |
| cfg_neg_clk | input | 1 | Inverts every clock edge in the cell |
| clk_en | input | 1 | Shared register update enable |
| lat_hold | input | 1 | Latch control: 0 transparent, 1 hold |
| pad_i | input | WIDTH | Resolved value present at the pads |
| dout0 | input | WIDTH | Fabric data, rising-edge half |
| dout1 | input | WIDTH | Fabric data, falling-edge half |
| oe_i | input | WIDTH | Fabric driver enable |
| din0 | output | WIDTH | Primary receive data |
| din1 | output | WIDTH | Falling-edge receive data |
| pad_o | output | WIDTH | Value to drive onto the pads |
| pad_oe | output | WIDTH | Pad driver enable, 0 means high impedance |

## Verification
The hardest case to reach is the double-rate transmit path under swapped edges, because its output depends on the clock level itself and on two registers loaded on different edges. The bench loads distinct patterns into the two data inputs, waits exactly one falling and one rising edge, and samples in the middle of each clock phase, first with normal and then with inverted edges. The pad is resolved in the bench with a short delay so that loopback values never race the capturing edge.

// File: rtl/pad_cell_pkg.sv
`timescale 1ns/1ps
package pad_cell_pkg;

   localparam int CFG_W = 6;

   // receive field, value of cfg[1:0]
   typedef enum logic [1:0] {
      RX_REG     = 2'b00,
      RX_THRU    = 2'b01,
      RX_REG_LAT = 2'b10,
      RX_LAT     = 2'b11
   } rx_mode_e;

   // transmit field, value of cfg[3:2]
   typedef enum logic [1:0] {
      TX_DDR     = 2'b00,
      TX_REG     = 2'b01,
      TX_THRU    = 2'b10,
      TX_REG_INV = 2'b11
   } tx_mode_e;

   // enable field, value of cfg[5:4]
   typedef enum logic [1:0] {
      EN_OFF = 2'b00,
      EN_ON  = 2'b01,
      EN_PIN = 2'b10,
      EN_REG = 2'b11
   } en_mode_e;

   typedef struct packed {
      en_mode_e en;
      tx_mode_e tx;
      rx_mode_e rx;
   } cell_cfg_t;

   function automatic cell_cfg_t split_cfg(input logic [CFG_W-1:0] w);
      cell_cfg_t c;
      c.rx = rx_mode_e'(w[1:0]);
      c.tx = tx_mode_e'(w[3:2]);
      c.en = en_mode_e'(w[5:4]);
      return c;
   endfunction

endpackage

// File: rtl/pad_cell_rx.sv
`timescale 1ns/1ps
module pad_cell_rx
   import pad_cell_pkg::*;
#(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             neg_clk,
   input  logic             rst_n,
   input  logic             cen,
   input  logic             hold,
   input  rx_mode_e         mode,
   input  logic [WIDTH-1:0] pad,
   output logic [WIDTH-1:0] q0,
   output logic [WIDTH-1:0] q1
);

   logic             clk_e;
   logic [WIDTH-1:0] rise_q;
   logic [WIDTH-1:0] fall_q;
   logic [WIDTH-1:0] lat_q;

   assign clk_e = clk ^ neg_clk;

   always_ff @(posedge clk_e or negedge rst_n) begin
      if (!rst_n)   rise_q <= '0;
      else if (cen) rise_q <= pad;
   end

   always_ff @(negedge clk_e or negedge rst_n) begin
      if (!rst_n)   fall_q <= '0;
      else if (cen) fall_q <= pad;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_lat
      logic lat_d;
      logic lat_bit;
      assign lat_d = (mode == RX_LAT) ? pad[i] : rise_q[i];
      always_latch begin
         if (!rst_n)     lat_bit <= 1'b0;
         else if (!hold) lat_bit <= lat_d;
      end
      assign lat_q[i] = lat_bit;
   end

   always_comb begin
      unique case (mode)
         RX_REG:  q0 = rise_q;
         RX_THRU: q0 = pad;
         default: q0 = lat_q;
      endcase
   end

   assign q1 = fall_q;

   // R2
   rx_reg_capture_chk: assert property (@(posedge clk_e) disable iff (!rst_n)
      (mode == RX_REG && cen) |=> (mode != RX_REG) || (q0 == $past(pad)));

   // R5
   rx_fall_capture_chk: assert property (@(negedge clk_e) disable iff (!rst_n)
      cen |=> (q1 == $past(pad)));

   // R6
   rx_hold_chk: assert property (@(posedge clk_e) disable iff (!rst_n)
      !cen |=> $stable(rise_q));

endmodule

// File: rtl/pad_cell_tx.sv
`timescale 1ns/1ps
module pad_cell_tx
   import pad_cell_pkg::*;
#(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             neg_clk,
   input  logic             rst_n,
   input  logic             cen,
   input  tx_mode_e         mode,
   input  logic [WIDTH-1:0] d0,
   input  logic [WIDTH-1:0] d1,
   output logic [WIDTH-1:0] dat
);

   logic             clk_e;
   logic [WIDTH-1:0] rise_d;
   logic [WIDTH-1:0] rise_q;
   logic [WIDTH-1:0] fall_q;

   assign clk_e  = clk ^ neg_clk;
   // one rising-edge register serves the plain, inverted and double-rate modes
   assign rise_d = (mode == TX_REG_INV) ? ~d0 : d0;

   always_ff @(posedge clk_e or negedge rst_n) begin
      if (!rst_n)   rise_q <= '0;
      else if (cen) rise_q <= rise_d;
   end

   always_ff @(negedge clk_e or negedge rst_n) begin
      if (!rst_n)   fall_q <= '0;
      else if (cen) fall_q <= d1;
   end

   always_comb begin
      unique case (mode)
         TX_DDR:  dat = clk_e ? rise_q : fall_q;
         TX_THRU: dat = d0;
         default: dat = rise_q;
      endcase
   end

   // R8
   tx_reg_inv_chk: assert property (@(posedge clk_e) disable iff (!rst_n)
      (mode == TX_REG_INV && cen) |=> (mode != TX_REG_INV) || (dat == ~$past(d0)));

   // R8
   tx_reg_chk: assert property (@(posedge clk_e) disable iff (!rst_n)
      (mode == TX_REG && cen) |=> (mode != TX_REG) || (dat == $past(d0)));

   // R6
   tx_hold_chk: assert property (@(negedge clk_e) disable iff (!rst_n)
      !cen |=> $stable(fall_q));

endmodule

// File: rtl/pad_cell_en.sv
`timescale 1ns/1ps
module pad_cell_en
   import pad_cell_pkg::*;
#(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             neg_clk,
   input  logic             rst_n,
   input  logic             cen,
   input  en_mode_e         mode,
   input  logic [WIDTH-1:0] oe_in,
   output logic [WIDTH-1:0] en
);

   logic             clk_e;
   logic [WIDTH-1:0] oe_q;

   assign clk_e = clk ^ neg_clk;

   always_ff @(posedge clk_e or negedge rst_n) begin
      if (!rst_n)   oe_q <= '0;
      else if (cen) oe_q <= oe_in;
   end

   always_comb begin
      unique case (mode)
         EN_OFF:  en = '0;
         EN_ON:   en = '1;
         EN_PIN:  en = oe_in;
         default: en = oe_q;
      endcase
   end

   // R10
   en_reg_chk: assert property (@(posedge clk_e) disable iff (!rst_n)
      (mode == EN_REG && cen) |=> (mode != EN_REG) || (en == $past(oe_in)));

endmodule

// File: rtl/pad_cell.sv
`timescale 1ns/1ps
module pad_cell
   import pad_cell_pkg::*;
#(
   parameter int WIDTH = 2
) (
   input  logic              clk_in,
   input  logic              clk_out,
   input  logic              rst_n,
   input  logic [CFG_W-1:0]  cfg_type,
   input  logic              cfg_neg_clk,
   input  logic              clk_en,
   input  logic              lat_hold,
   input  logic [WIDTH-1:0]  pad_i,
   input  logic [WIDTH-1:0]  dout0,
   input  logic [WIDTH-1:0]  dout1,
   input  logic [WIDTH-1:0]  oe_i,
   output logic [WIDTH-1:0]  din0,
   output logic [WIDTH-1:0]  din1,
   output logic [WIDTH-1:0]  pad_o,
   output logic [WIDTH-1:0]  pad_oe
);

   if (WIDTH < 1) begin : g_width_bad
      $error("pad_cell: WIDTH must be at least 1");
   end

   cell_cfg_t cfg;
   assign cfg = split_cfg(cfg_type);

   pad_cell_rx #(.WIDTH(WIDTH)) u_rx (
      .clk     (clk_in),
      .neg_clk (cfg_neg_clk),
      .rst_n   (rst_n),
      .cen     (clk_en),
      .hold    (lat_hold),
      .mode    (cfg.rx),
      .pad     (pad_i),
      .q0      (din0),
      .q1      (din1)
   );

   pad_cell_tx #(.WIDTH(WIDTH)) u_tx (
      .clk     (clk_out),
      .neg_clk (cfg_neg_clk),
      .rst_n   (rst_n),
      .cen     (clk_en),
      .mode    (cfg.tx),
      .d0      (dout0),
      .d1      (dout1),
      .dat     (pad_o)
   );

   pad_cell_en #(.WIDTH(WIDTH)) u_en (
      .clk     (clk_out),
      .neg_clk (cfg_neg_clk),
      .rst_n   (rst_n),
      .cen     (clk_en),
      .mode    (cfg.en),
      .oe_in   (oe_i),
      .en      (pad_oe)
   );

   // R10
   en_off_chk: assert property (@(posedge clk_out) disable iff (!rst_n)
      (cfg_type[5:4] == 2'b00) |-> (pad_oe == '0));

endmodule

// File: tb/pad_cell_bench.sv
`timescale 1ns/1ps
module pad_cell_bench;

   localparam int W = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [5:0]   cfg_type = 6'b000000;
   logic         cfg_neg_clk = 1'b0;
   logic         clk_en = 1'b1;
   logic         lat_hold = 1'b0;
   logic [W-1:0] ext = '0;
   logic [W-1:0] dout0 = '0;
   logic [W-1:0] dout1 = '0;
   logic [W-1:0] oe_i = '0;
   logic [W-1:0] pad_i;
   logic [W-1:0] din0, din1, pad_o, pad_oe;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   // tristate resolution of the pad: the cell wins where it drives
   assign #0.5 pad_i = (pad_oe & pad_o) | (~pad_oe & ext);

   pad_cell u_pad_cell (
      .clk_in(clk), .clk_out(clk), .rst_n(rst_n),
      .cfg_type(cfg_type), .cfg_neg_clk(cfg_neg_clk),
      .clk_en(clk_en), .lat_hold(lat_hold), .pad_i(pad_i),
      .dout0(dout0), .dout1(dout1), .oe_i(oe_i),
      .din0(din0), .din1(din1), .pad_o(pad_o), .pad_oe(pad_oe)
   );

   task automatic chk(input string req, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic after_rise();
      @(posedge clk); #2;
   endtask

   task automatic after_fall();
      @(negedge clk); #2;
   endtask

   task automatic t_reset();
      #10;
      chk("R1", "din0", din0, 2'b00);
      chk("R1", "din1", din1, 2'b00);
      chk("R1", "pad_o", pad_o, 2'b00);
      chk("R1", "pad_oe", pad_oe, 2'b00);
      @(negedge clk); #1 rst_n = 1'b1;
   endtask

   task automatic t_rx_reg();
      cfg_type = 6'b000000;
      after_fall(); ext = 2'b01; #1;
      chk("R2", "before edge", din0, 2'b00);
      after_rise();
      chk("R2", "captured", din0, 2'b01);
      ext = 2'b10;
      after_rise();
      chk("R2", "second capture", din0, 2'b10);
   endtask

   task automatic t_rx_thru();
      cfg_type = 6'b000001;
      ext = 2'b10; #1;
      chk("R3", "follow a", din0, 2'b10);
      ext = 2'b01; #1;
      chk("R3", "follow b", din0, 2'b01);
   endtask

   task automatic t_rx_latch();
      cfg_type = 6'b000011;
      lat_hold = 1'b0; ext = 2'b11; #1;
      chk("R4", "transparent", din0, 2'b11);
      lat_hold = 1'b1; #1; ext = 2'b00; #1;
      chk("R4", "held", din0, 2'b11);
      after_rise();
      chk("R4", "held over edge", din0, 2'b11);
      lat_hold = 1'b0; #1;
      chk("R4", "reopened", din0, 2'b00);
      cfg_type = 6'b000010;
      ext = 2'b01;
      after_rise();
      chk("R4", "reg then latch", din0, 2'b01);
      lat_hold = 1'b1; ext = 2'b10;
      after_rise();
      chk("R4", "latch blocks reg", din0, 2'b01);
      lat_hold = 1'b0; #1;
      chk("R4", "latch passes reg", din0, 2'b10);
   endtask

   task automatic t_rx_fall();
      cfg_type = 6'b000000;
      after_fall(); ext = 2'b10;
      after_rise(); after_fall();
      chk("R5", "fall capture", din1, 2'b10);
      ext = 2'b01;
      after_rise();
      chk("R5", "not on rise", din1, 2'b10);
      chk("R2", "rise capture", din0, 2'b01);
      after_fall();
      chk("R5", "next fall", din1, 2'b01);
   endtask

   task automatic t_cen();
      cfg_type = 6'b000000;
      after_rise(); ext = 2'b00;
      after_fall(); after_rise();
      clk_en = 1'b0; ext = 2'b11;
      after_fall();
      chk("R6", "din1 frozen", din1, 2'b00);
      after_rise();
      chk("R6", "din0 frozen", din0, 2'b00);
      clk_en = 1'b1;
      after_rise();
      chk("R6", "din0 resumes", din0, 2'b11);
      cfg_type = 6'b010100; dout0 = 2'b11;
      after_rise();
      chk("R6", "tx loaded", pad_o, 2'b11);
      clk_en = 1'b0; dout0 = 2'b00;
      after_rise();
      chk("R6", "tx frozen", pad_o, 2'b11);
      clk_en = 1'b1;
      after_rise();
      chk("R6", "tx resumes", pad_o, 2'b00);
   endtask

   task automatic t_tx_thru();
      cfg_type = 6'b011001;
      dout0 = 2'b10; #1;
      chk("R7", "pad_o a", pad_o, 2'b10);
      chk("R7", "driver on", pad_oe, 2'b11);
      dout0 = 2'b01; #2;
      chk("R7", "pad_o b", pad_o, 2'b01);
      chk("R7", "loopback", din0, 2'b01);
   endtask

   task automatic t_tx_reg();
      cfg_type = 6'b010100;
      dout0 = 2'b00;
      after_rise();
      chk("R8", "reg base", pad_o, 2'b00);
      dout0 = 2'b01; #1;
      chk("R8", "waits for edge", pad_o, 2'b00);
      after_rise();
      chk("R8", "reg loaded", pad_o, 2'b01);
      cfg_type = 6'b011100;
      after_rise();
      chk("R8", "inverted", pad_o, 2'b10);
   endtask

   task automatic t_ddr();
      cfg_type = 6'b010001;
      after_rise(); dout0 = 2'b10; dout1 = 2'b01;
      after_fall();
      chk("R9", "low phase", pad_o, 2'b01);
      after_rise();
      chk("R9", "high phase", pad_o, 2'b10);
      dout0 = 2'b11; dout1 = 2'b00; #1;
      chk("R9", "high phase stable", pad_o, 2'b10);
      after_fall();
      chk("R9", "low phase new", pad_o, 2'b00);
   endtask

   task automatic t_en();
      cfg_type = 6'b001000; #1;
      chk("R10", "off", pad_oe, 2'b00);
      cfg_type = 6'b101000; oe_i = 2'b10; #1;
      chk("R10", "pin", pad_oe, 2'b10);
      after_rise();
      oe_i = 2'b01; #1;
      chk("R10", "pin follows", pad_oe, 2'b01);
      cfg_type = 6'b111000; #1;
      chk("R10", "reg old", pad_oe, 2'b10);
      after_rise();
      chk("R10", "reg new", pad_oe, 2'b01);
      cfg_type = 6'b011000; #1;
      chk("R10", "always on", pad_oe, 2'b11);
   endtask

   task automatic t_negclk();
      cfg_type = 6'b000000;
      after_fall(); cfg_neg_clk = 1'b1;
      #1 ext = 2'b00;
      after_rise(); after_fall();
      ext = 2'b11;
      after_rise();
      chk("R11", "din0 waits for fall", din0, 2'b00);
      chk("R11", "din1 on rise", din1, 2'b11);
      after_fall();
      chk("R11", "din0 on fall", din0, 2'b11);
      cfg_type = 6'b010001;
      after_rise(); dout0 = 2'b10; dout1 = 2'b01;
      after_fall();
      chk("R11", "ddr low phase", pad_o, 2'b10);
      after_rise();
      chk("R11", "ddr high phase", pad_o, 2'b01);
      cfg_neg_clk = 1'b0;
   endtask

   initial begin
      t_reset();
      t_rx_reg();
      t_rx_thru();
      t_rx_latch();
      t_rx_fall();
      t_cen();
      t_tx_thru();
      t_tx_reg();
      t_ddr();
      t_en();
      t_negclk();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule